// File: doc/BRIEF.md
# Repeated String Transfer Sequencer

This block moves a run of equally sized elements from one place to another, one element at a time. A start pulse captures four things: a source pointer, a destination pointer, an element count, and a set of controls. The controls are the element size (1, 2, 4 or 8 bytes), a direction bit and a transfer mode. For each element the sequencer issues one read request and then one write request on a single request port. It waits for `req_ready_i` on each request. After the write completes it moves the active pointers by the element size and lowers the count by one.

The mode selects the kind of transfer. It can be a memory-to-memory copy. It can be a port input, where reads come from an I/O port number and writes go to memory. It can be a port output, where reads come from memory and writes go to the port. In the two port modes the 16-bit port number takes the place of one memory pointer, and that pointer is left unchanged. The live pointer and count values are always visible on the outputs, so when `done_o` pulses they hold the final values.

Top module: `str_move_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `req_valid_o` are 0, and `src_o`, `dst_o` and `cnt_o` are 0. While `busy_o` is 0, no request is issued.
- R2: In memory mode (`mode_i` = 0, and also 3), each element is one read (`req_we_o`=0) at the source pointer, followed by one write (`req_we_o`=1) at the destination pointer. The write carries the full `rsp_rdata_i` word that was captured when the read completed.
- R3: With `dir_i`=0 the active pointers increase after each element. With `dir_i`=1 they decrease. Arithmetic wraps modulo 2^AW.
- R4: The pointer step is 2^`size_i` bytes: `size_i` 0, 1, 2 and 3 give steps of 1, 2, 4 and 8.
- R5: The count drops by one after each write completes. `done_o` pulses high for exactly one cycle, in the cycle after the last write handshake. At that point `busy_o` is 0, `cnt_o` is 0 and the pointers hold their final values.
- R6: A start with `cnt_i`=0 issues no request and never raises `busy_o`. It gives a `done_o` pulse in the next cycle, and the pointers equal their start values.
- R7: In port-input mode (`mode_i`=1), each read goes to the zero-extended `port_i` with `req_io_o`=1. Each write goes to the destination pointer with `req_io_o`=0. `src_o` keeps its start value.
- R8: In port-output mode (`mode_i`=2), each read goes to the source pointer with `req_io_o`=0. Each write goes to the zero-extended `port_i` with `req_io_o`=1. `dst_o` keeps its start value.
- R9: While `req_valid_o` is 1 and `req_ready_i` is 0, the request address, `req_we_o` and `req_io_o` stay unchanged.
- R10: A `start_i` pulse while `busy_o` is 1 has no effect: the transfer in progress finishes with its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dir_i | input | 1 | 0 = step up, 1 = step down |
| size_i | input | 2 | Element size code, step = 2^size_i bytes |
| mode_i | input | 2 | 0/3 memory copy, 1 port input, 2 port output |
| src_i | input | AW | Initial source pointer |
| dst_i | input | AW | Initial destination pointer |
| cnt_i | input | CW | Element count |
| port_i | input | PW | I/O port number |
| req_valid_o | output | 1 | Request valid |
| req_we_o | output | 1 | 1 = write, 0 = read |
| req_io_o | output | 1 | Request targets I/O space |
| req_addr_o | output | AW | Request address |
| req_wdata_o | output | DW | Write data |
| req_ready_i | input | 1 | Request accepted this cycle; read data valid |
| rsp_rdata_i | input | DW | Read data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | AW | Live source pointer |
| dst_o | output | AW | Live destination pointer |
| cnt_o | output | CW | Live remaining count |

## Verification
Some internal faults show up on the very next request. A wrong step or direction does so: the next read or write lands at an address shifted away from the expected one. A count that is off by one appears at the end of the transfer. The run then has one write too many or too few, `done_o` arrives at the wrong time, and `cnt_o` reads back as non-zero. A broken mode latch sends a request to the wrong space or wrong address right from the first element. A port-mode pointer that should have stayed still is caught when the final `src_o` or `dst_o` is compared at `done_o`.

// File: rtl/str_seq_pkg.sv
package str_seq_pkg;
  typedef enum logic [1:0] {
    MODE_MEM      = 2'd0,
    MODE_PORT_IN  = 2'd1,
    MODE_PORT_OUT = 2'd2,
    MODE_MEM_ALT  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

  localparam int unsigned SIZE_W   = 2;
  localparam int unsigned NUM_PTRS = 2;
  localparam int unsigned PTR_SRC  = 0;
  localparam int unsigned PTR_DST  = 1;
endpackage

// File: rtl/str_seq_ptr.sv
module str_seq_ptr
  import str_seq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [AW-1:0]     init_i,
  input  logic              adv_i,
  input  logic              dec_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [AW-1:0]     ptr_o
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] step;

  assign step  = {{(AW-1){1'b0}}, 1'b1} << size_i;
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= init_i;
    end else if (adv_i) begin
      ptr_q <= dec_i ? ptr_q - step : ptr_q + step;
    end
  end

  // R3
  ptr_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (ptr_o != $past(ptr_o)));
endmodule

// File: rtl/str_seq_ctrl.sv
module str_seq_ctrl
  import str_seq_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 64,
  parameter int unsigned PW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        mode_i,
  input  logic [PW-1:0]     port_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              req_ready_i,
  input  logic [DW-1:0]     rdata_i,
  output logic              load_o,
  output logic              adv_src_o,
  output logic              adv_dst_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              dir_o,
  output logic              port_in_o,
  output logic              port_out_o,
  output logic [PW-1:0]     port_o,
  output logic [CW-1:0]     cnt_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_valid_o,
  output logic              req_we_o,
  output logic [DW-1:0]     wdata_o
);
  seq_state_e        state_q;
  xfer_mode_e        mode_q;
  logic [CW-1:0]     cnt_q;
  logic [SIZE_W-1:0] size_q;
  logic              dir_q;
  logic [PW-1:0]     port_q;
  logic [DW-1:0]     data_q;
  logic              done_q;
  logic              wr_fire;

  assign wr_fire     = (state_q == ST_WR) && req_ready_i;
  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign port_in_o   = (mode_q == MODE_PORT_IN);
  assign port_out_o  = (mode_q == MODE_PORT_OUT);
  assign adv_src_o   = wr_fire && !port_in_o;
  assign adv_dst_o   = wr_fire && !port_out_o;
  assign size_o      = size_q;
  assign dir_o       = dir_q;
  assign port_o      = port_q;
  assign cnt_o       = cnt_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign req_valid_o = busy_o;
  assign req_we_o    = (state_q == ST_WR);
  assign wdata_o     = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_MEM;
      cnt_q   <= '0;
      size_q  <= '0;
      dir_q   <= 1'b0;
      port_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q <= xfer_mode_e'(mode_i);
            size_q <= size_i;
            dir_q  <= dir_i;
            port_q <= port_i;
            cnt_q  <= cnt_i;
            if (cnt_i == '0) done_q  <= 1'b1;
            else             state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (req_ready_i) begin
            data_q  <= rdata_i;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (req_ready_i) begin
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_RD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_we_o && req_ready_i) |=> (cnt_o == $past(cnt_o) - CW'(1)));

  // R5
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R5
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && cnt_o == '0));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_valid_o);

  // R6
  zero_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && cnt_i == '0) |=> (done_o && !busy_o));
endmodule

// File: rtl/str_move_seq.sv
module str_move_seq
  import str_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64,
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        mode_i,
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic [PW-1:0]     port_i,
  output logic              req_valid_o,
  output logic              req_we_o,
  output logic              req_io_o,
  output logic [AW-1:0]     req_addr_o,
  output logic [DW-1:0]     req_wdata_o,
  input  logic              req_ready_i,
  input  logic [DW-1:0]     rsp_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [AW-1:0]     src_o,
  output logic [AW-1:0]     dst_o,
  output logic [CW-1:0]     cnt_o
);
  localparam int unsigned PAD_W = AW - PW;

  logic              load;
  logic              adv_src, adv_dst;
  logic [SIZE_W-1:0] size_q;
  logic              dir_q;
  logic              port_in, port_out;
  logic [PW-1:0]     port_q;
  logic [AW-1:0]     port_addr;
  logic [AW-1:0]     ptr_init [NUM_PTRS];
  logic              ptr_adv  [NUM_PTRS];
  logic [AW-1:0]     ptr_val  [NUM_PTRS];

  str_seq_ctrl #(.CW(CW), .DW(DW), .PW(PW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dir_i      (dir_i),
    .size_i     (size_i),
    .mode_i     (mode_i),
    .port_i     (port_i),
    .cnt_i      (cnt_i),
    .req_ready_i(req_ready_i),
    .rdata_i    (rsp_rdata_i),
    .load_o     (load),
    .adv_src_o  (adv_src),
    .adv_dst_o  (adv_dst),
    .size_o     (size_q),
    .dir_o      (dir_q),
    .port_in_o  (port_in),
    .port_out_o (port_out),
    .port_o     (port_q),
    .cnt_o      (cnt_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .req_valid_o(req_valid_o),
    .req_we_o   (req_we_o),
    .wdata_o    (req_wdata_o)
  );

  assign ptr_init[PTR_SRC] = src_i;
  assign ptr_init[PTR_DST] = dst_i;
  assign ptr_adv[PTR_SRC]  = adv_src;
  assign ptr_adv[PTR_DST]  = adv_dst;

  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
    str_seq_ptr #(.AW(AW)) u_ptr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load),
      .init_i(ptr_init[g]),
      .adv_i (ptr_adv[g]),
      .dec_i (dir_q),
      .size_i(size_q),
      .ptr_o (ptr_val[g])
    );
  end

  assign src_o     = ptr_val[PTR_SRC];
  assign dst_o     = ptr_val[PTR_DST];
  assign port_addr = {{PAD_W{1'b0}}, port_q};

  always_comb begin
    if (req_we_o) begin
      req_addr_o = port_out ? port_addr : dst_o;
      req_io_o   = req_valid_o && port_out;
    end else begin
      req_addr_o = port_in ? port_addr : src_o;
      req_io_o   = req_valid_o && port_in;
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_we_o) && $stable(req_io_o)));
endmodule

// File: tb/str_move_seq_test.sv
module str_move_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int CW = 16;
  localparam int PW = 16;
  localparam int LOG_D = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir = 1'b0;
  logic [1:0] size = '0, mode = '0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [CW-1:0] cnt = '0;
  logic [PW-1:0] port = '0;
  logic req_valid, req_we, req_io, ready = 1'b0;
  logic [AW-1:0] req_addr, src_o, dst_o;
  logic [DW-1:0] req_wdata, rdata;
  logic busy, done;
  logic [CW-1:0] cnt_o;

  int checks = 0, fails = 0;
  int lat = 0, hold_cnt = 0, unstable = 0, log_n = 0;
  bit busy_seen = 0;
  logic [AW-1:0] hold_addr;
  logic hold_we;
  logic          log_we   [LOG_D];
  logic          log_io   [LOG_D];
  logic [AW-1:0] log_addr [LOG_D];
  logic [DW-1:0] log_data [LOG_D];

  always #(CLK_PERIOD/2) clk = ~clk;

  str_move_seq #(.AW(AW), .DW(DW), .CW(CW), .PW(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir), .size_i(size),
    .mode_i(mode), .src_i(src), .dst_i(dst), .cnt_i(cnt), .port_i(port),
    .req_valid_o(req_valid), .req_we_o(req_we), .req_io_o(req_io),
    .req_addr_o(req_addr), .req_wdata_o(req_wdata), .req_ready_i(ready),
    .rsp_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o)
  );

  function automatic logic [DW-1:0] pattern(logic [AW-1:0] a, logic io);
    return io ? {32'hC0DE_0000 | a, ~a} : {a, a ^ 32'h5A5A_5A5A};
  endfunction

  assign rdata = pattern(req_addr, req_io);

  // responder and logger, active on the falling edge
  always @(negedge clk) begin
    if (busy) busy_seen = 1;
    if (req_valid) begin
      if (hold_cnt == 0) begin
        hold_addr = req_addr;
        hold_we   = req_we;
      end else if (req_addr != hold_addr || req_we != hold_we) begin
        unstable++;
      end
      if (hold_cnt >= lat) begin
        ready = 1'b1;
        hold_cnt = 0;
        if (log_n < LOG_D) begin
          log_we[log_n]   = req_we;
          log_io[log_n]   = req_io;
          log_addr[log_n] = req_addr;
          log_data[log_n] = req_wdata;
        end
        log_n++;
      end else begin
        ready = 1'b0;
        hold_cnt++;
      end
    end else begin
      ready = 1'b0;
      hold_cnt = 0;
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(busy == 0 && done == 0 && req_valid == 0, "R1", {busy, done, req_valid}, 0);
    check(src_o == 0 && dst_o == 0 && cnt_o == 0, "R1", {src_o, dst_o} | cnt_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic run(logic [1:0] m, logic d, logic [1:0] sz, logic [AW-1:0] s0,
                     logic [AW-1:0] d0, logic [PW-1:0] p, int n, int l, bit poke);
    logic [AW-1:0] step, rd_a, wr_a, pa, fs, fd;
    bit pin, pout;
    int waited;
    pin  = (m == 2'd1);
    pout = (m == 2'd2);
    step = 32'd1 << sz;
    pa   = {16'h0, p};
    @(negedge clk);
    mode = m; dir = d; size = sz; src = s0; dst = d0; port = p; cnt = CW'(n);
    lat = l; log_n = 0; busy_seen = 0; unstable = 0; start = 1'b1;
    waited = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done && waited < 5000) begin
      @(negedge clk);
      waited++;
      if (poke && waited == 2) begin
        start = 1'b1; src = ~s0; dst = ~d0; cnt = CW'(n + 5); dir = ~d; size = ~sz;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(done == 1'b1, "R5", done, 1);
    check(busy == 1'b0 && cnt_o == 0, "R5", {busy, cnt_o}, 0);
    if (n == 0) begin
      // R6
      check(waited == 0 && log_n == 0 && !busy_seen, "R6", log_n, 0);
      check(src_o == s0 && dst_o == d0, "R6", {src_o, dst_o}, {s0, d0});
    end else begin
      check(log_n == 2 * n, poke ? "R10" : "R5", log_n, 2 * n);
      for (int k = 0; k < n && 2 * k + 1 < LOG_D; k++) begin
        rd_a = pin  ? pa : (d ? s0 - step * k : s0 + step * k);
        wr_a = pout ? pa : (d ? d0 - step * k : d0 + step * k);
        check(!log_we[2*k] && log_addr[2*k] == rd_a && log_io[2*k] == pin,
              pin ? "R7" : "R4", log_addr[2*k], rd_a);
        check(log_we[2*k+1] && log_addr[2*k+1] == wr_a && log_io[2*k+1] == pout,
              pout ? "R8" : "R4", log_addr[2*k+1], wr_a);
        check(log_data[2*k+1] == pattern(rd_a, pin), "R2", log_data[2*k+1], pattern(rd_a, pin));
      end
    end
    fs = pin  ? s0 : (d ? s0 - step * n : s0 + step * n);
    fd = pout ? d0 : (d ? d0 - step * n : d0 + step * n);
    check(src_o == fs, pin ? "R7" : (poke ? "R10" : "R3"), src_o, fs);
    check(dst_o == fd, pout ? "R8" : (poke ? "R10" : "R3"), dst_o, fd);
    check(unstable == 0, "R9", unstable, 0);
    @(negedge clk);
    check(done == 1'b0, "R5", done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();                                                  // R1
    repeat (2) @(negedge clk);
    run(2'd0, 1'b0, 2'd0, 32'h1000, 32'h2000, 16'h0, 4, 0, 0);      // R2 R3 R4
    run(2'd0, 1'b1, 2'd3, 32'h8000, 32'h9000, 16'h0, 3, 2, 0);      // R3 R4 R9
    run(2'd0, 1'b0, 2'd1, 32'h0100, 32'h0300, 16'h0, 5, 1, 0);      // R4
    run(2'd3, 1'b1, 2'd2, 32'h0004, 32'h0100, 16'h0, 2, 0, 0);      // R2 R3 wrap
    run(2'd0, 1'b0, 2'd2, 32'h0500, 32'h0600, 16'h0, 0, 0, 0);      // R6
    run(2'd1, 1'b0, 2'd2, 32'hAAAA, 32'h4000, 16'h03F8, 3, 1, 0);   // R7
    run(2'd2, 1'b1, 2'd0, 32'h7000, 32'hBBBB, 16'h0080, 3, 0, 0);   // R8
    run(2'd0, 1'b0, 2'd2, 32'h3000, 32'h5000, 16'h0, 3, 1, 1);      // R10
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule